// File: doc/BRIEF.md
# Indexed RTC Control Register File

This block is the host-facing register file of a real-time clock. A host reaches it through two byte-wide locations. A write to the even location picks an index. A read or write at the odd location then reaches the byte at that index in a 128-entry space. Four entries, at indices 10 to 13, are control and status registers. The rest is plain battery-style storage.

The time-keeping logic lives elsewhere. It reports events to this block through three one-cycle strobes: periodic tick, alarm match and end of update. It also drives a level, `pre_update`, that is high during the short window before each once-per-second update. From these inputs the block keeps the interrupt flags, drives the interrupt line and shows the update-in-progress bit. Reading the status register returns its flags and clears them, which acknowledges the interrupt. Turning on an enable while its flag is already pending raises the interrupt at once.

Top module: `rtc_regfile`

## Requirements
- R1: A write to even address (`bus_addr`=0) loads the index register with the low 7 bits of the write data, so bit 7 is dropped. A read at the even address returns 0xFF.
- R2: A write at the odd address stores the byte at the current index, and a later odd read at that index returns it. This holds for every index outside 10 to 13.
- R3: Writes to index 12 (status) and index 13 are ignored. Index 13 always reads 0x80.
- R4: After `rst_n` the registers hold these values: index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00, and `irq` is 0.
- R5: Index 12 holds bit 7 = interrupt pending, bit 6 = periodic flag, bit 5 = alarm flag and bit 4 = update flag. An odd read of index 12 returns the register's value and clears it to 0. From the next cycle `irq` is 0.
- R6: Each event strobe sets its own flag, whatever the enables are. Index 11 holds the enables: bit 6 for periodic, bit 5 for alarm, bit 4 for update. An alarm or update strobe that newly sets an enabled flag sets bit 7 and raises `irq`. A periodic strobe raises `irq` whenever its enable is set. A strobe whose enable is clear leaves `irq` low.
- R7: A write to index 11 that enables a flag already pending in index 12 sets bit 7 and raises `irq` in the next cycle. Any other write to index 11 clears bit 7 and lowers `irq`.
- R8: A write to index 11 with bit 7 (halt updates) at 1 stores bit 4 as 0.
- R9: Bit 7 of index 10 is read-only: writes do not change it. While the clock runs, it reads as `pre_update` delayed by one cycle.
- R10: Bit 7 of index 10 reads 0 while index 10 bits 6:5 are both 1 (dividers held) or while index 11 bit 7 is 1.
- R11: A `ctl_reset` pulse clears bits 6, 5 and 3 of index 11 and all of index 12, and lowers `irq`.
- R12: An event strobe in the same cycle as a read of index 12 is not lost. The read returns the old value, and the new flag, with its interrupt, appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, loads the initial register values |
| ctl_reset | input | 1 | Synchronous reset of enables, flags and `irq` |
| bus_cs | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index location, 1 = data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid from the cycle after the access |
| evt_periodic | input | 1 | Periodic tick strobe |
| evt_alarm | input | 1 | Alarm match strobe |
| evt_update | input | 1 | Update-ended strobe |
| pre_update | input | 1 | High in the window before a once-per-second update |
| irq | output | 1 | Active-high interrupt line |

## Verification
The bench builds the block with the default `IDX_W` of 7, so the full 128-entry space is present. With that value the bench can check that bit 7 of a written index is dropped, and it can reach high indices such as 0x40 and 0x0E. The event tests cover these cases:
- an interrupt raised by a flag as it arrives;
- an interrupt raised later by a write to the enable register;
- an event that lands in the same cycle as the acknowledging read.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_reset,
  input  logic       bus_cs,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       evt_periodic,
  input  logic       evt_alarm,
  input  logic       evt_update,
  input  logic       pre_update,
  output logic       irq
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IX_A = IDX_W'(10);
  localparam logic [IDX_W-1:0] IX_B = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_C = IDX_W'(12);
  localparam logic [IDX_W-1:0] IX_D = IDX_W'(13);

  logic [IDX_W-1:0] idx_q;
  logic [6:0]       a_q;
  logic [7:0]       b_q, c_q, rdata_q;
  logic             uip_q;
  logic [7:0]       mem [DEPTH];

  wire wr_idx = bus_cs & bus_we & ~bus_addr;
  wire wr_dat = bus_cs & bus_we & bus_addr;
  wire rd_any = bus_cs & ~bus_we;
  wire rd_dat = rd_any & bus_addr;

  wire hit_a = idx_q == IX_A;
  wire hit_b = idx_q == IX_B;
  wire hit_c = idx_q == IX_C;
  wire hit_d = idx_q == IX_D;
  wire ctl_hit = hit_a | hit_b | hit_c | hit_d;

  wire run = ~b_q[7] & (a_q[6:5] != 2'b11);

  wire       wr_b   = wr_dat & hit_b;
  wire [7:0] b_in   = bus_wdata[7] ? (bus_wdata & 8'hEF) : bus_wdata;
  wire [7:0] b_nxt  = wr_b ? b_in : b_q;
  wire [7:0] c_base = (rd_dat & hit_c) ? 8'h00 : c_q;
  wire [2:0] ev     = {evt_periodic, evt_alarm, evt_update};
  wire [2:0] flg    = c_base[6:4] | ev;
  wire [2:0] fresh  = ev & ~c_base[6:4];
  wire       ev_irq = |({evt_periodic, fresh[1:0]} & b_nxt[6:4]);
  wire       irqf   = wr_b ? |(flg & b_nxt[6:4]) : (c_base[7] | ev_irq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      a_q     <= 7'h26;
      b_q     <= 8'h02;
      c_q     <= 8'h00;
      uip_q   <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      if (wr_idx) idx_q <= bus_wdata[IDX_W-1:0];
      if (wr_dat && hit_a) a_q <= bus_wdata[6:0];
      uip_q <= pre_update & run;
      if (rd_any) begin
        if (!bus_addr)  rdata_q <= 8'hFF;
        else if (hit_a) rdata_q <= {uip_q, a_q};
        else if (hit_b) rdata_q <= b_q;
        else if (hit_c) rdata_q <= c_q;
        else if (hit_d) rdata_q <= 8'h80;
        else            rdata_q <= mem[idx_q];
      end
      if (ctl_reset) begin
        b_q <= b_q & 8'h97;
        c_q <= 8'h00;
      end else begin
        b_q <= b_nxt;
        c_q <= {irqf, flg, c_base[3:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_dat && !ctl_hit) mem[idx_q] <= bus_wdata;
  end

  assign bus_rdata = rdata_q;
  assign irq       = c_q[7];
endmodule

module rtc_regfile_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_reset,
  input logic             bus_cs,
  input logic             bus_we,
  input logic             bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             evt_periodic,
  input logic             evt_alarm,
  input logic             evt_update,
  input logic             irq,
  input logic [IDX_W-1:0] idx_q,
  input logic [6:0]       a_q,
  input logic [7:0]       b_q,
  input logic [7:0]       c_q,
  input logic             uip_q
);
  wire any_evt = evt_periodic | evt_alarm | evt_update;
  wire dat_wr  = bus_cs & bus_we & bus_addr;
  wire dat_rd  = bus_cs & ~bus_we & bus_addr;
  wire at_b    = idx_q == IDX_W'(11);
  wire at_c    = idx_q == IDX_W'(12);

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs && bus_we && !bus_addr |=> idx_q == $past(bus_wdata[IDX_W-1:0]));

  // R3
  c_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && at_c && !any_evt && !ctl_reset |=> c_q == $past(c_q));

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd && at_c && !any_evt |=> !irq && c_q == 8'h00);

  // R6
  alarm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm && b_q[5] && !c_q[5] && !ctl_reset && !(dat_wr && at_b) |=> irq);

  // R8
  set_uie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && at_b && bus_wdata[7] && !ctl_reset |=> !b_q[4]);

  // R10
  uip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_q[7] || a_q[6:5] == 2'b11 |=> !uip_q);

  // R11
  ctl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> !irq && c_q == 8'h00 && (b_q & 8'h68) == 8'h00);
endmodule

bind rtc_regfile rtc_regfile_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset),
  .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
  .irq(irq), .idx_q(idx_q), .a_q(a_q), .b_q(b_q), .c_q(c_q), .uip_q(uip_q)
);

// File: tb/rtc_regfile_test.sv
module rtc_regfile_test;
  logic clk = 0, rst_n = 0, ctl_reset = 0;
  logic bus_cs = 0, bus_we = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic evt_periodic = 0, evt_alarm = 0, evt_update = 0, pre_update = 0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_regfile uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(logic we, logic a, logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd_reg(logic [7:0] ix, output logic [7:0] v);
    acc(1, 0, ix);
    acc(0, 1, 0);
    v = bus_rdata;
  endtask

  task automatic wr_reg(logic [7:0] ix, logic [7:0] d);
    acc(1, 0, ix);
    acc(1, 1, d);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    evt_periodic = (which == 0); evt_alarm = (which == 1); evt_update = (which == 2);
    @(negedge clk);
    evt_periodic = 0; evt_alarm = 0; evt_update = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R4 irq", {7'd0, irq}, 8'h00);
    rd_reg(10, v); check("R4 reg10", v, 8'h26);
    rd_reg(11, v); check("R4 reg11", v, 8'h02);
    rd_reg(12, v); check("R4 reg12", v, 8'h00);
  endtask

  task automatic t_index;
    logic [7:0] v;
    wr_reg(8'h8E, 8'h5A);
    wr_reg(8'h40, 8'hC3);
    rd_reg(8'h0E, v); check("R1 index masked / R2 store", v, 8'h5A);
    rd_reg(8'h40, v); check("R2 high index", v, 8'hC3);
    acc(0, 0, 0); check("R1 even read", bus_rdata, 8'hFF);
  endtask

  task automatic t_readonly;
    logic [7:0] v;
    wr_reg(12, 8'hFF);
    check("R3 irq after C write", {7'd0, irq}, 8'h00);
    rd_reg(12, v); check("R3 C write ignored", v, 8'h00);
    wr_reg(13, 8'h00);
    rd_reg(13, v); check("R3 D reads 0x80", v, 8'h80);
  endtask

  task automatic t_flags;
    logic [7:0] v;
    wr_reg(11, 8'h22);
    pulse(1); check("R6 alarm raises irq", {7'd0, irq}, 8'h01);
    rd_reg(12, v); check("R5 C value", v, 8'hA0);
    check("R5 irq lowered", {7'd0, irq}, 8'h00);
    rd_reg(12, v); check("R5 C cleared", v, 8'h00);
    pulse(2); check("R6 disabled flag no irq", {7'd0, irq}, 8'h00);
    rd_reg(12, v); check("R6 update flag set", v, 8'h10);
    pulse(1); check("R6 alarm again", {7'd0, irq}, 8'h01);
    wr_reg(11, 8'h02); check("R7 disable lowers irq", {7'd0, irq}, 8'h00);
    wr_reg(11, 8'h22); check("R7 enable pending raises irq", {7'd0, irq}, 8'h01);
    rd_reg(12, v); check("R7 C after re-enable", v, 8'hA0);
    wr_reg(11, 8'h42);
    pulse(0); check("R6 periodic raises irq", {7'd0, irq}, 8'h01);
    rd_reg(12, v); check("R6 periodic flags", v, 8'hC0);
    wr_reg(11, 8'h02);
  endtask

  task automatic t_set;
    logic [7:0] v;
    wr_reg(11, 8'h92);
    rd_reg(11, v); check("R8 SET clears update enable", v, 8'h82);
    wr_reg(11, 8'h02);
  endtask

  task automatic t_uip;
    logic [7:0] v;
    @(negedge clk); pre_update = 1;
    rd_reg(10, v); check("R9 UIP follows window", v, 8'hA6);
    wr_reg(10, 8'h26);
    rd_reg(10, v); check("R9 UIP not writable to 0", v, 8'hA6);
    @(negedge clk); pre_update = 0;
    wr_reg(10, 8'hA6);
    rd_reg(10, v); check("R9 UIP not writable to 1", v, 8'h26);
    @(negedge clk); pre_update = 1;
    wr_reg(10, 8'h66);
    rd_reg(10, v); check("R10 dividers held", v, 8'h66);
    wr_reg(10, 8'h26);
    wr_reg(11, 8'h82);
    rd_reg(10, v); check("R10 SET held", v, 8'h26);
    wr_reg(11, 8'h02);
    @(negedge clk); pre_update = 0;
  endtask

  task automatic t_ctl;
    logic [7:0] v;
    wr_reg(11, 8'h6A);
    pulse(1); check("R11 irq before reset", {7'd0, irq}, 8'h01);
    @(negedge clk); ctl_reset = 1;
    @(negedge clk); ctl_reset = 0;
    check("R11 irq lowered", {7'd0, irq}, 8'h00);
    rd_reg(11, v); check("R11 enables cleared", v, 8'h02);
    rd_reg(12, v); check("R11 flags cleared", v, 8'h00);
  endtask

  task automatic t_coincide;
    logic [7:0] v;
    wr_reg(11, 8'h22);
    pulse(2);
    acc(1, 0, 12);
    @(negedge clk);
    bus_cs = 1; bus_we = 0; bus_addr = 1; evt_alarm = 1;
    @(negedge clk);
    bus_cs = 0; evt_alarm = 0;
    check("R12 read returns old value", bus_rdata, 8'h10);
    check("R12 irq from coincident alarm", {7'd0, irq}, 8'h01);
    rd_reg(12, v); check("R12 alarm flag kept", v, 8'hA0);
    wr_reg(11, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_index();
    t_readonly();
    t_flags();
    t_set();
    t_uip();
    t_ctl();
    t_coincide();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule